// File: doc/BRIEF.md
# Multiplexed Bus Address Decoder

This block sits between a processor whose low address byte shares pins with its 8-bit data bus and a group of byte-wide memory banks. While the address strobe is high, the block passes the 20-bit physical address straight through. When the strobe drops, it holds that address, so the shared pins can carry data for the rest of the cycle.

The held address is split into a bank index and an in-bank offset. The index turns into one active-low chip select per bank. This happens only when the memory/IO qualifier marks a memory cycle, and only when the indexed bank is fitted. The bank layout is a compile-time parameter: two 512 KB banks, four 256 KB banks, or 128 banks of 8 KB. A second parameter picks full decoding, where every index bit counts. In partial decoding the topmost index bit (A19) is ignored, so the fitted banks appear twice in the 1 MB space.

The processor's read and write strobes are passed on to the selected bank. The block also drives the direction and enable of the external data transceiver.

Top module: `mux_bus_decoder`

## Requirements
- R1: When the address strobe falls, the physical address output holds the value present on the multiplexed low byte and the upper address bits during the last clock in which the strobe was high. It keeps that value, whatever the bus pins do, until the strobe rises again.
- R2: While the address strobe is high, the physical address output equals {upper bits, low byte} with no clock delay.
- R3: When the memory/IO qualifier is 1 (I/O cycle), every chip select is 1 and both bank strobes are 1.
- R4: In full decoding with the four-bank layout, A19:A18 forms the bank number n. Chip select bit n goes to 0 when bank n is fitted. The bank offset output carries A17:A0.
- R5: At most one chip select bit is 0 at any time.
- R6: An address whose bank number names a bank marked absent in the fitted mask selects nothing. Both bank strobes then stay 1. In full decoding the transceiver enable is 1 (off) even when the data-enable input is 0.
- R7: In partial decoding with the two-bank layout, A19 is ignored. Bank 0 (chip select bit 0) responds to both 20023h and A0023h with the same offset A18:A0. Chip select bit 1 never goes to 0.
- R8: In the 8 KB layout, A19:A13 forms the bank number (bit n of a 128-bit select vector goes to 0). The bank offset output carries A12:A0.
- R9: The bank read strobe is 0 exactly when the processor read strobe is 0, the cycle is a memory cycle and a bank is selected. The bank write strobe follows the same rule with the processor write strobe.
- R10: The transceiver direction output is 1 (toward the processor) exactly when the transmit/receive input is 0. When a bank is selected, the transceiver enable equals the data-enable input.
- R11: During reset, with the address strobe low, the physical address output is 00000h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ad_i | input | 8 | Multiplexed low address byte / data pins |
| a_hi_i | input | 12 | Address bits A19:A8 |
| ale_i | input | 1 | Address strobe, high while address is valid |
| io_m_i | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| rd_n_i | input | 1 | Processor read strobe, active low |
| wr_n_i | input | 1 | Processor write strobe, active low |
| dt_r_i | input | 1 | Transmit/receive: 0 = read, 1 = write |
| den_n_i | input | 1 | Data enable, active low |
| phys_addr_o | output | 20 | Held or passing physical address |
| bank_addr_o | output | 20 minus bank-number bits | In-bank offset |
| cs_n_o | output | bank count | Active-low chip selects, one per bank |
| mem_rd_n_o | output | 1 | Bank read strobe, active low |
| mem_wr_n_o | output | 1 | Bank write strobe, active low |
| xcvr_toward_cpu_o | output | 1 | Transceiver direction, 1 = toward processor |
| xcvr_oe_n_o | output | 1 | Transceiver enable, active low |

## Verification
The bench builds three copies that share one set of bus inputs. The first uses the four-bank layout with full decoding and bank 2 marked absent. This brings the unselected-address case and the forced transceiver disable within reach. The second uses the two-bank layout with partial decoding, so the A19 alias and the never-selected upper bank can be observed. The third uses the 128-bank layout with full decoding, which exercises the 7-bit bank number, the narrow offset and the extreme banks 0 and 127.

// File: rtl/mux_bus_decoder_pkg.sv
package mux_bus_decoder_pkg;

    localparam int ADDR_W = 20;
    localparam int LOW_W  = 8;
    localparam int HI_W   = ADDR_W - LOW_W;

    typedef enum logic [1:0] {
        LAYOUT_2X512  = 2'd0,
        LAYOUT_4X256  = 2'd1,
        LAYOUT_128X8K = 2'd2
    } layout_e;

    function automatic int sel_bits(layout_e lay);
        case (lay)
            LAYOUT_2X512:  return 1;
            LAYOUT_4X256:  return 2;
            default:       return 7;
        endcase
    endfunction

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } latch_st_t;

endpackage

// File: rtl/mbd_addr_latch.sv
module mbd_addr_latch
    import mux_bus_decoder_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale_i,
    input  logic [ADDR_W-1:0] live_addr_i,
    output logic [ADDR_W-1:0] addr_o
);

    latch_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ale_i) begin
            st_d.addr = live_addr_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // transparent while the strobe is high, held once it drops
    assign addr_o = ale_i ? live_addr_i : st_q.addr;

endmodule

// File: rtl/mbd_bank_select.sv
module mbd_bank_select
    import mux_bus_decoder_pkg::*;
#(
    parameter layout_e      LAYOUT      = LAYOUT_4X256,
    parameter bit           FULL_DECODE = 1'b1,
    parameter logic [127:0] FITTED      = {128{1'b1}},
    localparam int          SB          = sel_bits(LAYOUT),
    localparam int          NB          = 1 << SB,
    localparam int          OFS_W       = ADDR_W - SB
)(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              mem_cycle_i,
    output logic [NB-1:0]     cs_n_o,
    output logic [OFS_W-1:0]  offset_o,
    output logic              hit_o
);

    logic [SB-1:0] idx_raw;
    logic [SB-1:0] idx;
    logic [NB-1:0] fitted_v;

    assign idx_raw  = addr_i[ADDR_W-1 -: SB];
    assign offset_o = addr_i[OFS_W-1:0];
    assign fitted_v = FITTED[NB-1:0];

    always_comb begin
        idx = idx_raw;
        if (!FULL_DECODE) begin
            idx[SB-1] = 1'b0;
        end
    end

    assign hit_o = mem_cycle_i & fitted_v[idx];

    for (genvar g = 0; g < NB; g++) begin : g_cs
        assign cs_n_o[g] = ~(hit_o && (idx == SB'(g)));
    end

endmodule

// File: rtl/mbd_strobe_gate.sv
module mbd_strobe_gate #(
    parameter bit FULL_DECODE = 1'b1
)(
    input  logic hit_i,
    input  logic rd_n_i,
    input  logic wr_n_i,
    input  logic dt_r_i,
    input  logic den_n_i,
    output logic mem_rd_n_o,
    output logic mem_wr_n_o,
    output logic xcvr_toward_cpu_o,
    output logic xcvr_oe_n_o
);

    assign mem_rd_n_o        = ~(hit_i & ~rd_n_i);
    assign mem_wr_n_o        = ~(hit_i & ~wr_n_i);
    assign xcvr_toward_cpu_o = ~dt_r_i;

    if (FULL_DECODE) begin : g_full
        assign xcvr_oe_n_o = hit_i ? den_n_i : 1'b1;
    end else begin : g_part
        assign xcvr_oe_n_o = den_n_i;
    end

endmodule

// File: rtl/mux_bus_decoder.sv
module mux_bus_decoder
    import mux_bus_decoder_pkg::*;
#(
    parameter layout_e      LAYOUT      = LAYOUT_4X256,
    parameter bit           FULL_DECODE = 1'b1,
    parameter logic [127:0] FITTED      = {128{1'b1}},
    localparam int          SB          = sel_bits(LAYOUT),
    localparam int          NUM_BANKS   = 1 << SB,
    localparam int          OFS_W       = ADDR_W - SB
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LOW_W-1:0]     ad_i,
    input  logic [HI_W-1:0]      a_hi_i,
    input  logic                 ale_i,
    input  logic                 io_m_i,
    input  logic                 rd_n_i,
    input  logic                 wr_n_i,
    input  logic                 dt_r_i,
    input  logic                 den_n_i,
    output logic [ADDR_W-1:0]    phys_addr_o,
    output logic [OFS_W-1:0]     bank_addr_o,
    output logic [NUM_BANKS-1:0] cs_n_o,
    output logic                 mem_rd_n_o,
    output logic                 mem_wr_n_o,
    output logic                 xcvr_toward_cpu_o,
    output logic                 xcvr_oe_n_o
);

    logic hit;

    mbd_addr_latch u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .ale_i       (ale_i),
        .live_addr_i ({a_hi_i, ad_i}),
        .addr_o      (phys_addr_o)
    );

    mbd_bank_select #(
        .LAYOUT      (LAYOUT),
        .FULL_DECODE (FULL_DECODE),
        .FITTED      (FITTED)
    ) u_sel (
        .addr_i      (phys_addr_o),
        .mem_cycle_i (~io_m_i),
        .cs_n_o      (cs_n_o),
        .offset_o    (bank_addr_o),
        .hit_o       (hit)
    );

    mbd_strobe_gate #(
        .FULL_DECODE (FULL_DECODE)
    ) u_gate (
        .hit_i             (hit),
        .rd_n_i            (rd_n_i),
        .wr_n_i            (wr_n_i),
        .dt_r_i            (dt_r_i),
        .den_n_i           (den_n_i),
        .mem_rd_n_o        (mem_rd_n_o),
        .mem_wr_n_o        (mem_wr_n_o),
        .xcvr_toward_cpu_o (xcvr_toward_cpu_o),
        .xcvr_oe_n_o       (xcvr_oe_n_o)
    );

endmodule

// File: rtl/mux_bus_decoder_chk.sv
module mux_bus_decoder_chk #(
    parameter int NB = 4
)(
    input logic          clk,
    input logic          rst_n,
    input logic          ale_i,
    input logic          io_m_i,
    input logic          rd_n_i,
    input logic          wr_n_i,
    input logic          dt_r_i,
    input logic [19:0]   phys_addr_o,
    input logic [NB-1:0] cs_n_o,
    input logic          mem_rd_n_o,
    input logic          mem_wr_n_o,
    input logic          xcvr_toward_cpu_o
);

    // R1
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ale_i && !$past(ale_i)) |-> $stable(phys_addr_o));

    // R3
    io_no_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_m_i |-> (&cs_n_o && mem_rd_n_o && mem_wr_n_o));

    // R5
    one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n_o));

    // R9
    rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_n_o |-> (!rd_n_i && !io_m_i && !(&cs_n_o)));

    // R9
    wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n_o |-> (!wr_n_i && !io_m_i && !(&cs_n_o)));

    // R10
    dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xcvr_toward_cpu_o == !dt_r_i);

endmodule

bind mux_bus_decoder mux_bus_decoder_chk #(.NB(NUM_BANKS)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .ale_i             (ale_i),
    .io_m_i            (io_m_i),
    .rd_n_i            (rd_n_i),
    .wr_n_i            (wr_n_i),
    .dt_r_i            (dt_r_i),
    .phys_addr_o       (phys_addr_o),
    .cs_n_o            (cs_n_o),
    .mem_rd_n_o        (mem_rd_n_o),
    .mem_wr_n_o        (mem_wr_n_o),
    .xcvr_toward_cpu_o (xcvr_toward_cpu_o)
);

// File: tb/mux_bus_decoder_bench.sv
module mux_bus_decoder_bench;
    import mux_bus_decoder_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ad_i = 8'h00;
    logic [11:0] a_hi_i = 12'h000;
    logic       ale_i = 1'b0;
    logic       io_m_i = 1'b0;
    logic       rd_n_i = 1'b1;
    logic       wr_n_i = 1'b1;
    logic       dt_r_i = 1'b0;
    logic       den_n_i = 1'b1;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    // main copy: four banks, full decoding, bank 2 absent
    logic [19:0] f_phys;
    logic [17:0] f_ofs;
    logic [3:0]  f_cs;
    logic        f_rd, f_wr, f_dir, f_oe;

    mux_bus_decoder #(
        .LAYOUT(LAYOUT_4X256), .FULL_DECODE(1'b1), .FITTED(128'hB)
    ) u_mux_bus_decoder (
        .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .a_hi_i(a_hi_i), .ale_i(ale_i),
        .io_m_i(io_m_i), .rd_n_i(rd_n_i), .wr_n_i(wr_n_i), .dt_r_i(dt_r_i),
        .den_n_i(den_n_i), .phys_addr_o(f_phys), .bank_addr_o(f_ofs),
        .cs_n_o(f_cs), .mem_rd_n_o(f_rd), .mem_wr_n_o(f_wr),
        .xcvr_toward_cpu_o(f_dir), .xcvr_oe_n_o(f_oe)
    );

    // partial copy: two banks, A19 ignored
    logic [19:0] p_phys;
    logic [18:0] p_ofs;
    logic [1:0]  p_cs;
    logic        p_rd, p_wr, p_dir, p_oe;

    mux_bus_decoder #(
        .LAYOUT(LAYOUT_2X512), .FULL_DECODE(1'b0)
    ) u_mux_bus_decoder_p (
        .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .a_hi_i(a_hi_i), .ale_i(ale_i),
        .io_m_i(io_m_i), .rd_n_i(rd_n_i), .wr_n_i(wr_n_i), .dt_r_i(dt_r_i),
        .den_n_i(den_n_i), .phys_addr_o(p_phys), .bank_addr_o(p_ofs),
        .cs_n_o(p_cs), .mem_rd_n_o(p_rd), .mem_wr_n_o(p_wr),
        .xcvr_toward_cpu_o(p_dir), .xcvr_oe_n_o(p_oe)
    );

    // 8 KB copy: 128 banks, full decoding
    logic [19:0]  k_phys;
    logic [12:0]  k_ofs;
    logic [127:0] k_cs;
    logic         k_rd, k_wr, k_dir, k_oe;

    mux_bus_decoder #(
        .LAYOUT(LAYOUT_128X8K), .FULL_DECODE(1'b1)
    ) u_mux_bus_decoder_k (
        .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .a_hi_i(a_hi_i), .ale_i(ale_i),
        .io_m_i(io_m_i), .rd_n_i(rd_n_i), .wr_n_i(wr_n_i), .dt_r_i(dt_r_i),
        .den_n_i(den_n_i), .phys_addr_o(k_phys), .bank_addr_o(k_ofs),
        .cs_n_o(k_cs), .mem_rd_n_o(k_rd), .mem_wr_n_o(k_wr),
        .xcvr_toward_cpu_o(k_dir), .xcvr_oe_n_o(k_oe)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // address phase, then data phase with strobes applied
    task automatic bus_cycle(input logic [19:0] a, input logic io, input logic rd, input logic wr);
        @(negedge clk);
        ad_i    = a[7:0];
        a_hi_i  = a[19:8];
        ale_i   = 1'b1;
        io_m_i  = io;
        rd_n_i  = 1'b1;
        wr_n_i  = 1'b1;
        dt_r_i  = wr;
        den_n_i = 1'b1;
        @(negedge clk);
        ale_i   = 1'b0;
        ad_i    = 8'h5A;
        rd_n_i  = ~rd;
        wr_n_i  = ~wr;
        den_n_i = 1'b0;
        #2;
    endtask

    // {address, io qualifier, expected chip selects} for the main copy
    localparam logic [24:0] VEC [8] = '{
        {20'h00010, 1'b0, 4'b1110},
        {20'h3FFFF, 1'b0, 4'b1110},
        {20'h40000, 1'b0, 4'b1101},
        {20'h4ABCD, 1'b0, 4'b1101},
        {20'h81234, 1'b0, 4'b1111},
        {20'hC1234, 1'b0, 4'b0111},
        {20'hFFFFF, 1'b0, 4'b0111},
        {20'hC1234, 1'b1, 4'b1111}
    };

    initial begin
        #(20 * 20000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset value of the held address
        check("R11 reset address", 128'(f_phys), 128'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 R5 R6 R9 R3 table walk
        for (int i = 0; i < 8; i++) begin
            logic [19:0] a;
            logic        io;
            logic [3:0]  exp_cs;
            a      = VEC[i][24:5];
            io     = VEC[i][4];
            exp_cs = VEC[i][3:0];
            bus_cycle(a, io, 1'b1, 1'b0);
            check("R4 R6 R3 chip selects", 128'(f_cs), 128'(exp_cs));
            check("R4 offset", 128'(f_ofs), 128'(a[17:0]));
            check("R9 R6 read strobe", 128'(f_rd), 128'(&exp_cs));
            check("R9 write idle", 128'(f_wr), 128'h1);
            check("R6 R10 transceiver enable", 128'(f_oe), 128'(&exp_cs));
            check("R10 direction read", 128'(f_dir), 128'h1);
            check("R5 one select", 128'($countones(~f_cs) <= 1), 128'h1);
        end

        // R2 transparency while the strobe is high
        @(negedge clk);
        ad_i   = 8'h77;
        a_hi_i = 12'h123;
        ale_i  = 1'b1;
        #1;
        check("R2 transparent", 128'(f_phys), 128'h12377);

        // R1 hold after strobe drops while pins change
        bus_cycle(20'h4ABCD, 1'b0, 1'b0, 1'b1);
        ad_i   = 8'hE1;
        a_hi_i = 12'hFFF;
        #1;
        check("R1 held address", 128'(f_phys), 128'h4ABCD);
        @(negedge clk);
        check("R1 held address later", 128'(f_phys), 128'h4ABCD);
        // R9 write path
        check("R9 write strobe", 128'(f_wr), 128'h0);
        check("R9 read idle on write", 128'(f_rd), 128'h1);
        // R10 direction on write, enable follows data enable
        check("R10 direction write", 128'(f_dir), 128'h0);
        check("R10 enable follows", 128'(f_oe), 128'h0);
        den_n_i = 1'b1;
        #1;
        check("R10 enable released", 128'(f_oe), 128'h1);

        // R7 partial decoding alias
        bus_cycle(20'h20023, 1'b0, 1'b1, 1'b0);
        check("R7 low half select", 128'(p_cs), 128'h2);
        check("R7 low half offset", 128'(p_ofs), 128'h20023);
        bus_cycle(20'hA0023, 1'b0, 1'b1, 1'b0);
        check("R7 high half alias", 128'(p_cs), 128'h2);
        check("R7 same offset", 128'(p_ofs), 128'h20023);
        check("R7 read strobe", 128'(p_rd), 128'h0);
        // R3 partial copy I/O cycle; enable follows data enable
        bus_cycle(20'hA0023, 1'b1, 1'b1, 1'b0);
        check("R3 partial io", 128'(p_cs), 128'h3);
        check("R3 partial strobe", 128'(p_rd), 128'h1);
        check("R10 partial enable", 128'(p_oe), 128'h0);
        check("R6 full enable forced", 128'(f_oe), 128'h1);

        // R8 128-bank layout
        bus_cycle(20'h2A000, 1'b0, 1'b1, 1'b0);
        check("R8 bank 21", k_cs, ~(128'h1 << 21));
        check("R8 offset zero", 128'(k_ofs), 128'h0);
        bus_cycle(20'hFFFFF, 1'b0, 1'b1, 1'b0);
        check("R8 bank 127", k_cs, ~(128'h1 << 127));
        check("R8 offset max", 128'(k_ofs), 128'h1FFF);
        bus_cycle(20'h01FFF, 1'b0, 1'b0, 1'b1);
        check("R8 bank 0", k_cs, ~128'h1);
        check("R9 8k write", 128'(k_wr), 128'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule